// File: doc/BRIEF.md
# Head-per-track disk command front end

This block is the processor-facing side of a head-per-track disk controller. The processor talks to it with single-cycle I/O strobes. Each strobe carries a kind (control, output, input or sense), a function code and a data word. The block replies one cycle later with an acknowledge, a skip flag, read data and a bad-function flag. A start control launches a two-word command load. The first word gives the direction, surface and track. The second word gives a character address, which the block checks before it hands the transfer to the engine behind it.

During a transfer the engine reports two things: each word boundary (loading the buffer on reads, and asking for the next word) and completion. The block keeps the busy, ready, access-error, data-error, end-of-range and interrupt flags. When a start selects channel mode and a channel is assigned, the block issues a one-cycle channel request each time ready is set. The storage and the channel arbitration live outside the block.

Top module: `fhdc_top`

## Requirements
- R1: Reset clears busy, ready, both error flags, end-of-range, the interrupt, the command words and the buffer, and returns the sequencer to idle. Right after reset, sense code 1 (not busy) skips and sense code 0 (ready) does not.
- R2: A control strobe with function 3 (channel mode) or 7 (bus mode) while not busy does four things on the next cycle: it sets busy and ready, clears end-of-range and both error flags, and makes the sequencer expect the first command word. A start while busy changes nothing.
- R3: An output strobe with function 0 is taken, and answered with skip, only while ready is 1. When the sequencer expects the first word, the data becomes command word 1, the sequencer then expects the second word and ready stays 1. When the sequencer is idle, the data goes to the buffer (driven on `xfer_data`) and ready clears. An output while ready is 0 has no skip and no effect.
- R4: Command word 1 has write in bit 15, the surface in bits 13..10 and the track in bits 9..4. Command word 2 has the character address in bits 11..0, and the word address is that address shifted right by one. A valid second word gives a one-cycle `xfer_start` pulse, and the `xfer_*` fields show the decoded values.
- R5: A second word raises an access error if any of these holds: the word address is 1536 or more, `store_present` is 0, or the surface is not below `surf_count`. The access error clears busy and ready, sets the interrupt, and suppresses `xfer_start`.
- R6: After a valid second word, ready becomes 1 for a write and 0 for a read.
- R7: An input strobe with function 0 while ready is 1 returns the buffer with skip and clears ready. Otherwise it returns 0 with no skip.
- R8: A sense strobe skips on code 0 if ready, 1 if not busy, 2 if no data error, 3 if no access error, and 4 if no interrupt is pending. Any other code never skips and is never flagged bad.
- R9: A channel-mode start with `chan_assigned` at 1 enables channel requests. `chan_req` then pulses one cycle after each event that sets ready. A bus-mode start, or a start with no channel assigned, gives no requests.
- R10: Control function 4 sets end-of-range and clears the interrupt. Control functions other than 3, 4 and 7, and output or input strobes with a nonzero function, set `io_bad_func` and have no other effect.
- R11: While busy with the sequencer idle, `eng_word_evt` sets ready and, on a read, loads `eng_word` into the buffer. `eng_done` clears busy, sets the interrupt, and sets the data error if `eng_err` is 1. A same-cycle set of ready or of the interrupt wins over a same-cycle clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_strobe | input | 1 | I/O strobe valid |
| io_kind | input | 2 | 0 control, 1 output, 2 input, 3 sense |
| io_func | input | FUNC_W | Function code |
| io_wdata | input | 16 | Output data |
| io_ack | output | 1 | Registered acknowledge of a strobe |
| io_skip | output | 1 | Skip response |
| io_rdata | output | 16 | Input data |
| io_bad_func | output | 1 | Function rejected |
| store_present | input | 1 | Storage attached |
| surf_count | input | SURF_W | Configured surface count |
| chan_assigned | input | 1 | A transfer channel is assigned |
| eng_word_evt | input | 1 | Engine reached a word boundary |
| eng_word | input | 16 | Word read by the engine |
| eng_done | input | 1 | Engine finished the transfer |
| eng_err | input | 1 | Engine saw a data error (with eng_done) |
| busy | output | 1 | Operation in progress |
| ready | output | 1 | Word may be exchanged |
| access_err | output | 1 | Access error |
| data_err | output | 1 | Data error |
| end_range | output | 1 | End-of-range flag |
| irq | output | 1 | Interrupt request |
| chan_req | output | 1 | Channel request pulse |
| xfer_start | output | 1 | Transfer hand-off pulse |
| xfer_write | output | 1 | Transfer direction, 1 write |
| xfer_surface | output | 4 | Selected surface |
| xfer_track | output | 6 | Selected track |
| xfer_char_addr | output | 12 | Start character address |
| xfer_word_addr | output | 11 | Start word address |
| xfer_data | output | 16 | Buffer word for the engine |

## Verification
Two things can land in the same cycle: an engine word boundary, which sets ready, and a processor input, which clears it. Likewise, engine completion (which raises the interrupt) can coincide with control function 4 (which clears it). The bench forces both pairs in directed cases. It expects ready to stay 1 with the old buffer returned, and the interrupt to stay 1. Random traffic also lets such pairs meet freely, and a bench reference model judges every cycle.

// File: rtl/fhdc_pkg.sv
package fhdc_pkg;

  typedef enum logic [1:0] {
    IO_CTL   = 2'd0,
    IO_OUT   = 2'd1,
    IO_IN    = 2'd2,
    IO_SENSE = 2'd3
  } io_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WORD1 = 2'd1,
    PH_WORD2 = 2'd2
  } phase_e;

  localparam int CMD_W = 16;

  function automatic logic cmd_is_write(input logic [CMD_W-1:0] w);
    return w[15];
  endfunction

  function automatic logic [3:0] cmd_surface(input logic [CMD_W-1:0] w);
    return w[13:10];
  endfunction

  function automatic logic [5:0] cmd_track(input logic [CMD_W-1:0] w);
    return w[9:4];
  endfunction

  function automatic logic [11:0] cmd_char_addr(input logic [CMD_W-1:0] w);
    return w[11:0];
  endfunction

  function automatic logic [10:0] char_to_word(input logic [11:0] ca);
    return ca[11:1];
  endfunction

  // sense code table: each code answers one status question
  function automatic logic sense_hit(input logic [2:0] code, input logic rdy,
                                     input logic bsy, input logic derr,
                                     input logic aerr, input logic ireq);
    case (code)
      3'd0:    return rdy;
      3'd1:    return !bsy;
      3'd2:    return !derr;
      3'd3:    return !aerr;
      3'd4:    return !ireq;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fhdc_decode.sv
module fhdc_decode
  import fhdc_pkg::*;
#(
  parameter int FUNC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [1:0]        kind,
  input  logic [FUNC_W-1:0] func,
  input  logic              busy,
  input  logic              ready,
  input  phase_e            phase,
  output logic              ev_start,
  output logic              ev_start_dma,
  output logic              ev_eor,
  output logic              ev_cw1,
  output logic              ev_cw2,
  output logic              ev_dout,
  output logic              ev_in,
  output logic              ev_sense,
  output logic              bad_func
);

  localparam logic [FUNC_W-1:0] F_START_CH  = FUNC_W'(3);
  localparam logic [FUNC_W-1:0] F_END_RANGE = FUNC_W'(4);
  localparam logic [FUNC_W-1:0] F_START_BUS = FUNC_W'(7);

  logic is_ctl, is_out, is_in, fn_zero, ctl_start, out_ok;

  always_comb begin
    is_ctl       = strobe && (io_kind_e'(kind) == IO_CTL);
    is_out       = strobe && (io_kind_e'(kind) == IO_OUT);
    is_in        = strobe && (io_kind_e'(kind) == IO_IN);
    ev_sense     = strobe && (io_kind_e'(kind) == IO_SENSE);
    fn_zero      = (func == '0);
    ctl_start    = is_ctl && ((func == F_START_CH) || (func == F_START_BUS));
    ev_start     = ctl_start && !busy;
    ev_start_dma = (func == F_START_CH);
    ev_eor       = is_ctl && (func == F_END_RANGE);
    out_ok       = is_out && fn_zero && ready;
    ev_cw1       = out_ok && (phase == PH_WORD1);
    ev_cw2       = out_ok && (phase == PH_WORD2);
    ev_dout      = out_ok && (phase == PH_IDLE);
    ev_in        = is_in && fn_zero && ready;
    bad_func     = (is_ctl && !ctl_start && !ev_eor) || ((is_out || is_in) && !fn_zero);
  end

  p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_eor, ev_cw1, ev_cw2, ev_dout, ev_in, ev_sense}));

  p_bad_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_func |-> !(ev_start || ev_cw1 || ev_cw2 || ev_dout || ev_in));

endmodule

// File: rtl/fhdc_seq.sv
module fhdc_seq
  import fhdc_pkg::*;
#(
  parameter int WORDS_PER_TRACK = 1536,
  parameter int SURF_W          = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_cw1,
  input  logic             ev_cw2,
  input  logic             ev_dout,
  input  logic             eng_load,
  input  logic [CMD_W-1:0] wdata,
  input  logic [CMD_W-1:0] eng_word,
  input  logic             store_present,
  input  logic [SURF_W-1:0] surf_count,
  output phase_e           phase,
  output logic [CMD_W-1:0] cw1,
  output logic [CMD_W-1:0] cw2,
  output logic [CMD_W-1:0] buf_word,
  output logic             cw2_ok,
  output logic             cw2_bad
);

  logic [11:0] new_ca;
  logic [10:0] new_wa;
  logic        addr_bad, surf_bad;

  always_comb begin
    new_ca   = cmd_char_addr(wdata);
    new_wa   = char_to_word(new_ca);
    addr_bad = int'(new_wa) >= WORDS_PER_TRACK;
    surf_bad = int'(cmd_surface(cw1)) >= int'(surf_count);
    cw2_bad  = ev_cw2 && (addr_bad || !store_present || surf_bad);
    cw2_ok   = ev_cw2 && !(addr_bad || !store_present || surf_bad);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cw1      <= '0;
      cw2      <= '0;
      buf_word <= '0;
    end else begin
      if (ev_start) phase <= PH_WORD1;
      if (ev_cw1) begin
        cw1   <= wdata;
        phase <= PH_WORD2;
      end
      if (ev_cw2) begin
        cw2   <= wdata;
        phase <= PH_IDLE;
      end
      if (ev_dout) buf_word <= wdata;
      if (eng_load && !cmd_is_write(cw1)) buf_word <= eng_word;
    end
  end

  p_cw1_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cw1 |=> (phase == PH_WORD2) && (cw1 == $past(wdata)));

  p_cw2_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cw2 |=> (phase == PH_IDLE) && (cw2 == $past(wdata)));

endmodule

// File: rtl/fhdc_flags.sv
module fhdc_flags
  import fhdc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_start,
  input  logic   ev_start_dma,
  input  logic   chan_assigned,
  input  logic   ev_eor,
  input  logic   ev_cw1,
  input  logic   ev_dout,
  input  logic   ev_in,
  input  logic   cw2_ok,
  input  logic   cw2_bad,
  input  logic   is_write,
  input  phase_e phase,
  input  logic   eng_word_evt,
  input  logic   eng_done,
  input  logic   eng_err,
  output logic   busy,
  output logic   ready,
  output logic   access_err,
  output logic   data_err,
  output logic   end_range,
  output logic   irq,
  output logic   dma,
  output logic   chan_req,
  output logic   eng_load
);

  logic xfer_live, done_ok, rdy_set, rdy_clr, irq_set, dma_nx;

  always_comb begin
    xfer_live = busy && (phase == PH_IDLE);
    eng_load  = eng_word_evt && xfer_live;
    done_ok   = eng_done && xfer_live;
    rdy_set   = ev_start || ev_cw1 || (cw2_ok && is_write) || eng_load;
    rdy_clr   = ev_in || ev_dout || (cw2_ok && !is_write) || cw2_bad;
    irq_set   = cw2_bad || done_ok;
    dma_nx    = ev_start ? (ev_start_dma && chan_assigned) : dma;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      ready      <= 1'b0;
      access_err <= 1'b0;
      data_err   <= 1'b0;
      end_range  <= 1'b0;
      irq        <= 1'b0;
      dma        <= 1'b0;
      chan_req   <= 1'b0;
    end else begin
      if (ev_start) begin
        busy       <= 1'b1;
        access_err <= 1'b0;
        data_err   <= 1'b0;
        end_range  <= 1'b0;
      end
      dma <= dma_nx;
      if (cw2_bad || done_ok) busy <= 1'b0;
      if (cw2_bad) access_err <= 1'b1;
      if (done_ok && eng_err) data_err <= 1'b1;
      if (ev_eor) end_range <= 1'b1;
      if (rdy_set) ready <= 1'b1;
      else if (rdy_clr) ready <= 1'b0;
      if (irq_set) irq <= 1'b1;
      else if (ev_eor) irq <= 1'b0;
      chan_req <= rdy_set && dma_nx;
    end
  end

  p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> busy && ready && !access_err && !data_err && !end_range);

  p_phase_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> busy);

  p_access_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cw2_bad |=> access_err && !busy && !ready && irq);

  p_creq_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_req |-> dma && ready);

  p_word_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load |=> ready);

endmodule

// File: rtl/fhdc_top.sv
module fhdc_top
  import fhdc_pkg::*;
#(
  parameter int FUNC_W          = 6,
  parameter int WORDS_PER_TRACK = 1536,
  parameter int MAX_SURF        = 16,
  localparam int SURF_W         = $clog2(MAX_SURF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_strobe,
  input  logic [1:0]        io_kind,
  input  logic [FUNC_W-1:0] io_func,
  input  logic [15:0]       io_wdata,
  output logic              io_ack,
  output logic              io_skip,
  output logic [15:0]       io_rdata,
  output logic              io_bad_func,
  input  logic              store_present,
  input  logic [SURF_W-1:0] surf_count,
  input  logic              chan_assigned,
  input  logic              eng_word_evt,
  input  logic [15:0]       eng_word,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              busy,
  output logic              ready,
  output logic              access_err,
  output logic              data_err,
  output logic              end_range,
  output logic              irq,
  output logic              chan_req,
  output logic              xfer_start,
  output logic              xfer_write,
  output logic [3:0]        xfer_surface,
  output logic [5:0]        xfer_track,
  output logic [11:0]       xfer_char_addr,
  output logic [10:0]       xfer_word_addr,
  output logic [15:0]       xfer_data
);

  phase_e           phase;
  logic             ev_start, ev_start_dma, ev_eor, ev_cw1, ev_cw2, ev_dout, ev_in, ev_sense;
  logic             bad_func, cw2_ok, cw2_bad, dma, eng_load, sense_skip;
  logic [CMD_W-1:0] cw1, cw2, buf_word;

  fhdc_decode #(.FUNC_W(FUNC_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .strobe(io_strobe), .kind(io_kind), .func(io_func),
    .busy(busy), .ready(ready), .phase(phase),
    .ev_start(ev_start), .ev_start_dma(ev_start_dma), .ev_eor(ev_eor),
    .ev_cw1(ev_cw1), .ev_cw2(ev_cw2), .ev_dout(ev_dout), .ev_in(ev_in),
    .ev_sense(ev_sense), .bad_func(bad_func)
  );

  fhdc_seq #(.WORDS_PER_TRACK(WORDS_PER_TRACK), .SURF_W(SURF_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_cw1(ev_cw1), .ev_cw2(ev_cw2),
    .ev_dout(ev_dout), .eng_load(eng_load), .wdata(io_wdata), .eng_word(eng_word),
    .store_present(store_present), .surf_count(surf_count),
    .phase(phase), .cw1(cw1), .cw2(cw2), .buf_word(buf_word),
    .cw2_ok(cw2_ok), .cw2_bad(cw2_bad)
  );

  fhdc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_start_dma(ev_start_dma),
    .chan_assigned(chan_assigned), .ev_eor(ev_eor), .ev_cw1(ev_cw1),
    .ev_dout(ev_dout), .ev_in(ev_in), .cw2_ok(cw2_ok), .cw2_bad(cw2_bad),
    .is_write(cmd_is_write(cw1)), .phase(phase), .eng_word_evt(eng_word_evt),
    .eng_done(eng_done), .eng_err(eng_err),
    .busy(busy), .ready(ready), .access_err(access_err), .data_err(data_err),
    .end_range(end_range), .irq(irq), .dma(dma), .chan_req(chan_req),
    .eng_load(eng_load)
  );

  always_comb begin
    sense_skip = ev_sense && (io_func < FUNC_W'(5)) &&
                 sense_hit(io_func[2:0], ready, busy, data_err, access_err, irq);
    xfer_write     = cmd_is_write(cw1);
    xfer_surface   = cmd_surface(cw1);
    xfer_track     = cmd_track(cw1);
    xfer_char_addr = cmd_char_addr(cw2);
    xfer_word_addr = char_to_word(cmd_char_addr(cw2));
    xfer_data      = buf_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_ack      <= 1'b0;
      io_skip     <= 1'b0;
      io_rdata    <= '0;
      io_bad_func <= 1'b0;
      xfer_start  <= 1'b0;
    end else begin
      io_ack      <= io_strobe;
      io_skip     <= ev_cw1 || ev_cw2 || ev_dout || ev_in || sense_skip;
      io_rdata    <= ev_in ? buf_word : '0;
      io_bad_func <= bad_func;
      xfer_start  <= cw2_ok;
    end
  end

  p_skip_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_skip || io_bad_func) |-> io_ack);

  p_xfer_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> busy && !access_err && (phase == PH_IDLE));

  p_rdata_on_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rdata != '0) |-> io_skip);

endmodule

// File: tb/fhdc_top_tb.sv
module fhdc_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_strobe = 1'b0;
  logic [1:0]  io_kind = '0;
  logic [5:0]  io_func = '0;
  logic [15:0] io_wdata = '0;
  logic        store_present = 1'b1;
  logic [4:0]  surf_count = 5'd4;
  logic        chan_assigned = 1'b0;
  logic        eng_word_evt = 1'b0;
  logic [15:0] eng_word = '0;
  logic        eng_done = 1'b0;
  logic        eng_err = 1'b0;

  logic        io_ack, io_skip, io_bad_func, busy, ready, access_err, data_err;
  logic        end_range, irq, chan_req, xfer_start, xfer_write;
  logic [15:0] io_rdata, xfer_data;
  logic [3:0]  xfer_surface;
  logic [5:0]  xfer_track;
  logic [11:0] xfer_char_addr;
  logic [10:0] xfer_word_addr;

  int checks = 0;
  int errors = 0;

  fhdc_top u_dut (
    .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_kind(io_kind),
    .io_func(io_func), .io_wdata(io_wdata), .io_ack(io_ack), .io_skip(io_skip),
    .io_rdata(io_rdata), .io_bad_func(io_bad_func), .store_present(store_present),
    .surf_count(surf_count), .chan_assigned(chan_assigned),
    .eng_word_evt(eng_word_evt), .eng_word(eng_word), .eng_done(eng_done),
    .eng_err(eng_err), .busy(busy), .ready(ready), .access_err(access_err),
    .data_err(data_err), .end_range(end_range), .irq(irq), .chan_req(chan_req),
    .xfer_start(xfer_start), .xfer_write(xfer_write), .xfer_surface(xfer_surface),
    .xfer_track(xfer_track), .xfer_char_addr(xfer_char_addr),
    .xfer_word_addr(xfer_word_addr), .xfer_data(xfer_data)
  );

  always #2 clk = ~clk;

  // reference model state
  bit m_busy, m_ready, m_ace, m_dte, m_eor, m_irq, m_dma;
  int m_ph;
  logic [15:0] m_cw1, m_cw2, m_buf;
  bit e_ack, e_skip, e_bad, e_xs, e_cr;
  logic [15:0] e_rdata;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_busy = 0; m_ready = 0; m_ace = 0; m_dte = 0; m_eor = 0; m_irq = 0; m_dma = 0;
    m_ph = 0; m_cw1 = '0; m_cw2 = '0; m_buf = '0;
  endtask

  function automatic bit sense_expect(input int code);
    case (code)
      0: return m_ready;
      1: return !m_busy;
      2: return !m_dte;
      3: return !m_ace;
      4: return !m_irq;
      default: return 0;
    endcase
  endfunction

  // advance one cycle: compute expectation from current inputs, then compare
  task automatic step(input string tag);
    bit ctl, outk, ink, sns, fz, stq, st, eo, oo, ii, c1, c2, dout, badc, ok2, bad2;
    bit live, el, dn, rset, rclr, dnx;
    int wa;
    ctl  = io_strobe && io_kind == 2'd0;
    outk = io_strobe && io_kind == 2'd1;
    ink  = io_strobe && io_kind == 2'd2;
    sns  = io_strobe && io_kind == 2'd3;
    fz   = io_func == 0;
    stq  = ctl && (io_func == 3 || io_func == 7);
    st   = stq && !m_busy;
    eo   = ctl && io_func == 4;
    oo   = outk && fz && m_ready;
    ii   = ink && fz && m_ready;
    c1   = oo && m_ph == 1;
    c2   = oo && m_ph == 2;
    dout = oo && m_ph == 0;
    wa   = int'(io_wdata[11:0]) / 2;
    badc = (wa >= 1536) || !store_present || (int'(m_cw1[13:10]) >= int'(surf_count));
    ok2  = c2 && !badc;
    bad2 = c2 && badc;
    live = m_busy && m_ph == 0;
    el   = eng_word_evt && live;
    dn   = eng_done && live;
    e_ack   = io_strobe;
    e_bad   = (ctl && !stq && !eo) || ((outk || ink) && !fz);
    e_skip  = oo || ii || (sns && sense_expect(int'(io_func)));
    e_rdata = ii ? m_buf : 16'h0;
    e_xs    = ok2;
    rset = st || c1 || (ok2 && m_cw1[15]) || el;
    rclr = ii || dout || (ok2 && !m_cw1[15]) || bad2;
    dnx  = st ? (io_func == 3 && chan_assigned) : m_dma;
    e_cr = rset && dnx;
    // next state
    if (st) begin m_busy = 1; m_ace = 0; m_dte = 0; m_eor = 0; m_ph = 1; end
    m_dma = dnx;
    if (c1) begin m_cw1 = io_wdata; m_ph = 2; end
    if (c2) begin m_cw2 = io_wdata; m_ph = 0; end
    if (bad2 || dn) m_busy = 0;
    if (bad2) m_ace = 1;
    if (dn && eng_err) m_dte = 1;
    if (eo) m_eor = 1;
    if (dout) m_buf = io_wdata;
    if (el && !m_cw1[15]) m_buf = eng_word;
    if (rset) m_ready = 1; else if (rclr) m_ready = 0;
    if (bad2 || dn) m_irq = 1; else if (eo) m_irq = 0;
    @(negedge clk);
    chk(io_ack, e_ack, tag, "io_ack");
    chk(io_skip, e_skip, tag, "io_skip");
    chk(io_rdata, e_rdata, tag, "io_rdata");
    chk(io_bad_func, e_bad, "R10", "io_bad_func");
    chk(busy, m_busy, tag, "busy");
    chk(ready, m_ready, tag, "ready");
    chk(access_err, m_ace, "R5", "access_err");
    chk(data_err, m_dte, "R11", "data_err");
    chk(end_range, m_eor, "R10", "end_range");
    chk(irq, m_irq, "R11", "irq");
    chk(chan_req, e_cr, "R9", "chan_req");
    chk(xfer_start, e_xs, "R4", "xfer_start");
    chk(xfer_data, m_buf, "R3", "xfer_data");
    if (e_xs) begin
      chk(xfer_write, m_cw1[15], "R4", "xfer_write");
      chk(xfer_surface, m_cw1[13:10], "R4", "xfer_surface");
      chk(xfer_track, m_cw1[9:4], "R4", "xfer_track");
      chk(xfer_char_addr, m_cw2[11:0], "R4", "xfer_char_addr");
      chk(xfer_word_addr, 11'(m_cw2[11:0] >> 1), "R4", "xfer_word_addr");
    end
    io_strobe = 0; eng_word_evt = 0; eng_done = 0; eng_err = 0;
  endtask

  task automatic io(input int kind, input int func, input logic [15:0] data,
                    input string tag);
    io_strobe = 1; io_kind = 2'(kind); io_func = 6'(func); io_wdata = data;
    step(tag);
  endtask

  task automatic eng(input bit wevt, input logic [15:0] w, input bit done,
                     input bit err, input string tag);
    eng_word_evt = wevt; eng_word = w; eng_done = done; eng_err = err;
    step(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk({busy, ready, access_err, data_err, end_range, irq}, 0, "R1", "flags after reset");
    chk(xfer_data, 0, "R1", "buffer after reset");
    io(3, 1, 0, "R1");
    chk(io_skip, 1, "R1", "sense not-busy skips");
    io(3, 0, 0, "R8");
    chk(io_skip, 0, "R8", "sense ready no skip");
    // R3: output while not ready ignored
    io(1, 0, 16'h1234, "R3");
    chk(io_skip, 0, "R3", "output without ready");
    chk(xfer_data, 0, "R3", "buffer untouched");
    // write op in bus mode
    chan_assigned = 1; surf_count = 5'd4; store_present = 1;
    io(0, 7, 0, "R2");
    chk({busy, ready}, 2'b11, "R2", "start sets busy ready");
    chk(chan_req, 0, "R9", "bus mode no request");
    io(0, 3, 0, "R2");  // start while busy: ignored
    io(1, 0, 16'h8000 | (16'd2 << 10) | (16'd5 << 4), "R3");
    chk(ready, 1, "R3", "ready kept after word 1");
    io(1, 0, 16'h00A5, "R4");
    chk(xfer_start, 1, "R4", "hand-off pulse");
    chk(xfer_surface, 2, "R4", "surface");
    chk(xfer_track, 5, "R4", "track");
    chk(xfer_word_addr, 11'h52, "R4", "word address");
    chk(ready, 1, "R6", "write leaves ready");
    io(1, 0, 16'hBEEF, "R3");
    chk(ready, 0, "R3", "data out clears ready");
    chk(xfer_data, 16'hBEEF, "R3", "buffer filled");
    eng(1, 16'h5555, 0, 0, "R11");
    chk(xfer_data, 16'hBEEF, "R11", "write keeps buffer");
    chk(ready, 1, "R11", "word event sets ready");
    // conflict: done and end-range in the same cycle
    io_strobe = 1; io_kind = 2'd0; io_func = 6'd4;
    eng(0, 0, 1, 1, "R11");
    chk({busy, irq, data_err, end_range}, 4'b0111, "R11", "done wins irq");
    io(3, 2, 0, "R8");
    chk(io_skip, 0, "R8", "data error no skip");
    io(3, 4, 0, "R8");
    chk(io_skip, 0, "R8", "irq pending no skip");
    io(0, 4, 0, "R10");
    chk(irq, 0, "R10", "end-range clears irq");
    io(3, 6, 0, "R8");
    chk({io_skip, io_bad_func}, 0, "R8", "sense code 6");
    // access error boundaries: word address 1536, surface limit, absent storage
    io(0, 7, 0, "R2");
    io(1, 0, 16'h0000 | (16'd3 << 10), "R3");
    io(1, 0, 16'h0C00, "R5");
    chk({access_err, busy, irq, xfer_start}, 4'b1010, "R5", "address 1536");
    io(0, 7, 0, "R2");
    chk(access_err, 0, "R2", "start clears access error");
    io(1, 0, 16'h0000 | (16'd4 << 10), "R3");
    io(1, 0, 16'h0002, "R5");
    chk(access_err, 1, "R5", "surface at count");
    io(0, 7, 0, "R2");
    io(1, 0, 16'h0000 | (16'd3 << 10), "R3");
    store_present = 0;
    io(1, 0, 16'h0002, "R5");
    chk(access_err, 1, "R5", "storage absent");
    store_present = 1;
    // read op in channel mode, address 1535 valid
    io(0, 3, 0, "R9");
    chk(chan_req, 1, "R9", "request after start");
    io(1, 0, 16'h0000 | (16'd1 << 10) | (16'd9 << 4), "R9");
    chk(chan_req, 1, "R9", "request after word 1");
    io(1, 0, 16'h0BFF, "R6");
    chk({xfer_start, ready, chan_req}, 3'b100, "R6", "read clears ready");
    chk(xfer_word_addr, 11'd1535, "R4", "last word address");
    eng(1, 16'hA1B2, 0, 0, "R11");
    chk({ready, chan_req}, 2'b11, "R9", "word event request");
    chk(xfer_data, 16'hA1B2, "R11", "read loads buffer");
    // conflict: engine word and input in the same cycle
    io_strobe = 1; io_kind = 2'd2; io_func = 6'd0;
    eng(1, 16'hC3D4, 0, 0, "R11");
    chk(io_rdata, 16'hA1B2, "R7", "old buffer returned");
    chk(ready, 1, "R11", "set wins over clear");
    io(2, 0, 0, "R7");
    chk({io_skip, ready}, 2'b10, "R7", "input clears ready");
    chk(io_rdata, 16'hC3D4, "R7", "input data");
    io(2, 0, 0, "R7");
    chk({io_skip, io_rdata}, 0, "R7", "input without ready");
    io(0, 5, 0, "R10");
    chk(io_bad_func, 1, "R10", "control 5 bad");
    io(2, 2, 0, "R10");
    chk(io_bad_func, 1, "R10", "input func 2 bad");
    eng(0, 0, 1, 0, "R11");
    // channel-mode start with no channel assigned
    chan_assigned = 0;
    io(0, 3, 0, "R9");
    chk(chan_req, 0, "R9", "no channel no request");
    // reset mid-operation
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    model_reset();
    chk({busy, ready, irq}, 0, "R1", "reset mid-operation");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int k;
      int fsel;
      string tg;
      k = int'($urandom % 4);
      fsel = int'($urandom % 8);
      if ($urandom % 16 == 0) store_present = ($urandom % 8) != 0;
      if ($urandom % 16 == 0) surf_count = 5'(1 + $urandom % 16);
      if ($urandom % 16 == 0) chan_assigned = $urandom % 2;
      io_strobe = ($urandom % 4) != 0;
      io_kind = 2'(k);
      case (fsel)
        0, 1: io_func = 6'd0;
        2: io_func = 6'd1;
        3: io_func = 6'd2;
        4: io_func = 6'($urandom % 2 ? 3 : 7);
        5: io_func = 6'd4;
        6: io_func = 6'd3;
        default: io_func = 6'(5 + $urandom % 3);
      endcase
      io_wdata = 16'($urandom);
      if (m_ph == 2 && ($urandom % 4 != 0)) io_wdata[11:0] = 12'($urandom % 3072);
      eng_word_evt = ($urandom % 5) == 0;
      eng_word = 16'($urandom);
      eng_done = ($urandom % 20) == 0;
      eng_err = $urandom % 2;
      case (k)
        0: tg = "R2";
        1: tg = "R3";
        2: tg = "R7";
        default: tg = "R8";
      endcase
      step(tg);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule